// File: doc/BRIEF.md
# Signal Degrade Bit-Error-Rate Detector

This block decides whether a receive line has entered, or left, a signal degrade condition, using the parity error count that arrives once per frame. The count is taken from either the section (B1) or the line (B2) parity source, chosen by a select input. Errors are summed over a monitoring block of a programmable number of frames. Each finished block is judged against an error threshold. A measurement interval of a programmable number of blocks then counts the blocks that qualified.

Two state-machine states, `SD_CLEAR` and `SD_DEGRADED`, choose which of two independent parameter sets is active. Each set holds frames per block, blocks per interval, an error threshold and a block count threshold. In `SD_CLEAR`, a block qualifies when it is bad, meaning its errors are at or above the declare error threshold. The *declare* transition `SD_CLEAR -> SD_DEGRADED` fires as soon as the bad-block count reaches the declare count threshold. In `SD_DEGRADED`, a block qualifies when it is good, meaning its errors are below the clear error threshold. The *clear* transition `SD_DEGRADED -> SD_CLEAR` fires when the good-block count reaches the clear count threshold. The one-shot inputs drive two further transitions, *force-declare* (`-> SD_DEGRADED`) and *force-clear* (`-> SD_CLEAR`).

Every change of state sets a sticky delta flag, which raises an interrupt unless it is masked. Each state change or force restarts every counter, so the newly active parameter set starts from an empty interval.

Top module: `sdeg_detector`

## Requirements
- R1: After reset the state is clear (`sd_state`=0), `sd_delta`=0 and `sd_irq`=0.
- R2: While clear, a block of `set_frames` valid frames is bad when the sum of its selected error counts is at least `set_err_thr`. The state becomes degraded (`sd_state`=1) on the clock edge that samples the frame completing the block in which the bad-block count of the interval reaches `set_blk_thr`, without waiting for the interval to end.
- R3: When an interval of `set_blocks` (or `clr_blocks`) blocks ends without reaching the count threshold, the block and qualifying-block counts return to zero. Nothing from that interval carries into the next one.
- R4: While degraded, a block of `clr_frames` frames is good when its error sum is below `clr_err_thr`. The state returns to clear on the edge that completes the block in which the good-block count reaches `clr_blk_thr`.
- R5: The four `set_*` parameters apply only while the state is clear, and the four `clr_*` parameters apply only while it is degraded.
- R6: `err_sel`=0 counts `b1_errs` and `err_sel`=1 counts `b2_errs`. The unselected input has no effect.
- R7: A one-cycle `force_set` makes the state degraded on the next edge, and a one-cycle `force_clear` makes it clear. When both are high together, the state becomes clear.
- R8: `sd_delta` becomes 1 on every edge where the state changes, and it never sets without a state change. It stays 1 until the edge where `delta_ack` is high and no state change happens in that same cycle; a change in that cycle wins.
- R9: `sd_irq` is 1 exactly when `sd_delta` is 1 and `irq_mask` is 0.
- R10: Every state change and every force pulse, including one that leaves the state unchanged, restarts the frame, error, block and qualifying-block counters.
- R11: A cycle with `frame_valid`=0 adds no frame and no errors.
- R12: A value of 0 in a frames-per-block or blocks-per-interval setting is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_valid | input | 1 | One-cycle pulse per received frame |
| err_sel | input | 1 | Error source: 0 = B1 count, 1 = B2 count |
| b1_errs | input | ERR_W | B1 parity error count for this frame |
| b2_errs | input | ERR_W | B2 parity error count for this frame |
| set_frames | input | FRM_W | Frames per block while clear |
| set_blocks | input | BLK_W | Blocks per interval while clear |
| set_err_thr | input | ETHR_W | Bad-block error threshold (at or above) |
| set_blk_thr | input | BTHR_W | Bad blocks needed to declare |
| clr_frames | input | FRM_W | Frames per block while degraded |
| clr_blocks | input | BLK_W | Blocks per interval while degraded |
| clr_err_thr | input | ETHR_W | Good-block error threshold (below) |
| clr_blk_thr | input | BTHR_W | Good blocks needed to clear |
| force_set | input | 1 | One-shot force to degraded |
| force_clear | input | 1 | One-shot force to clear, wins over force_set |
| delta_ack | input | 1 | Clears the change flag |
| irq_mask | input | 1 | 1 masks the interrupt |
| sd_state | output | 1 | 1 = signal degraded |
| sd_delta | output | 1 | Sticky state-change flag |
| sd_irq | output | 1 | Unmasked change interrupt |

## Verification
The bench builds the detector with the frame counter and block counter each four bits wide. The error and threshold widths keep their defaults. The declare set uses two-frame blocks, three-block intervals and a count threshold of two. The clear set uses single-frame blocks, two-block intervals and a count threshold of two. With these values, interval expiry, equality at the error threshold, a swapped parameter set, the unselected error input and a restart after a force all appear within a few dozen frames. Each of these corner cases changes the cycle in which the state flips.

// File: rtl/sdeg_pkg.sv
package sdeg_pkg;

    typedef enum logic {
        SD_CLEAR    = 1'b0,
        SD_DEGRADED = 1'b1
    } sd_state_e;

endpackage

// File: rtl/sdeg_block_acc.sv
module sdeg_block_acc #(
    parameter int ERR_W  = 4,
    parameter int FRM_W  = 19,
    parameter int ETHR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              frame_valid,
    input  logic              degraded,
    input  logic [ERR_W-1:0]  err_in,
    input  logic [FRM_W-1:0]  frames_cfg,
    input  logic [ETHR_W-1:0] thr_cfg,
    output logic              block_end,
    output logic              block_qual
);

    localparam int SUM_W = ETHR_W + 1;
    localparam int TOT_W = ((SUM_W > ERR_W) ? SUM_W : ERR_W) + 1;
    localparam logic [SUM_W-1:0] SUM_MAX = '1;

    logic [FRM_W-1:0] fc_q;
    logic [FRM_W-1:0] frames_eff;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_sat;
    logic [TOT_W-1:0] total;

    // error sum including the current frame, saturated above any threshold
    always_comb begin
        frames_eff = (frames_cfg == '0) ? FRM_W'(1) : frames_cfg;
        total      = TOT_W'(sum_q) + TOT_W'(err_in);
        sum_sat    = (total > TOT_W'(SUM_MAX)) ? SUM_MAX : total[SUM_W-1:0];
        block_end  = frame_valid && (fc_q == frames_eff - FRM_W'(1));
        block_qual = degraded ? (sum_sat <  SUM_W'(thr_cfg))
                              : (sum_sat >= SUM_W'(thr_cfg));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fc_q  <= '0;
            sum_q <= '0;
        end else if (frame_valid) begin
            if (block_end) begin
                fc_q  <= '0;
                sum_q <= '0;
            end else begin
                fc_q  <= fc_q + FRM_W'(1);
                sum_q <= sum_sat;
            end
        end
    end

    // R10: a restart leaves frame and error accumulators empty
    a_r10_acc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> (fc_q == '0 && sum_q == '0));

    // R11: idle cycles leave the accumulators alone
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !restart) |=> ($stable(fc_q) && $stable(sum_q)));

endmodule

// File: rtl/sdeg_interval.sv
module sdeg_interval #(
    parameter int BLK_W  = 12,
    parameter int BTHR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              block_end,
    input  logic              block_qual,
    input  logic [BLK_W-1:0]  blocks_cfg,
    input  logic [BTHR_W-1:0] count_thr,
    output logic              hit
);

    localparam int CMP_W = ((BLK_W > BTHR_W) ? BLK_W : BTHR_W) + 1;

    logic [BLK_W-1:0] bc_q;
    logic [BLK_W-1:0] qc_q;
    logic [BLK_W-1:0] blocks_eff;
    logic [CMP_W-1:0] qc_next;
    logic             expire;

    always_comb begin
        blocks_eff = (blocks_cfg == '0) ? BLK_W'(1) : blocks_cfg;
        qc_next    = CMP_W'(qc_q) + CMP_W'(block_qual);
        hit        = block_end && (qc_next >= CMP_W'(count_thr));
        expire     = block_end && !hit && (bc_q == blocks_eff - BLK_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart || expire) begin
            bc_q <= '0;
            qc_q <= '0;
        end else if (block_end) begin
            bc_q <= bc_q + BLK_W'(1);
            qc_q <= qc_next[BLK_W-1:0];
        end
    end

    // R3: qualifying blocks never outnumber blocks seen in the interval
    a_r3_qual_le_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        qc_q <= bc_q);

    // R3: an expired interval starts from empty counts
    a_r3_expiry_reset: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (bc_q == '0 && qc_q == '0));

endmodule

// File: rtl/sdeg_state_fsm.sv
module sdeg_state_fsm
    import sdeg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      force_set,
    input  logic      force_clear,
    input  logic      delta_ack,
    input  logic      irq_mask,
    output sd_state_e state,
    output logic      restart,
    output logic      delta,
    output logic      irq
);

    sd_state_e state_q;
    sd_state_e state_d;
    logic      delta_q;

    // next state: evaluation first, forces override, force_clear highest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_CLEAR:    if (hit) state_d = SD_DEGRADED;
            SD_DEGRADED: if (hit) state_d = SD_CLEAR;
            default:     state_d = SD_CLEAR;
        endcase
        if (force_clear) begin
            state_d = SD_CLEAR;
        end else if (force_set) begin
            state_d = SD_DEGRADED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SD_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: sticky delta, interrupt and counter restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delta_q <= 1'b0;
        end else if (state_d != state_q) begin
            delta_q <= 1'b1;
        end else if (delta_ack) begin
            delta_q <= 1'b0;
        end
    end

    always_comb begin
        state   = state_q;
        delta   = delta_q;
        irq     = delta_q && !irq_mask;
        restart = hit || force_set || force_clear;
    end

    // R7: force_clear wins over everything
    a_r7_force_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        force_clear |=> (state_q == SD_CLEAR));

    // R7: a lone force_set lands in degraded
    a_r7_force_set: assert property (@(posedge clk) disable iff (!rst_n)
        (force_set && !force_clear) |=> (state_q == SD_DEGRADED));

    // R8: every state change leaves the delta flag set
    a_r8_delta_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> delta_q);

    // R8: the delta flag only rises together with a state change
    a_r8_no_spurious_delta: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q) |-> (state_q != $past(state_q)));

    // R8: without an acknowledge the flag holds
    a_r8_delta_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_q && !delta_ack) |=> delta_q);

    // R2: a threshold hit without forces flips the state
    a_r2_hit_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !force_set && !force_clear) |=> (state_q != $past(state_q)));

endmodule

// File: rtl/sdeg_detector.sv
module sdeg_detector
    import sdeg_pkg::*;
#(
    parameter int ERR_W  = 4,
    parameter int FRM_W  = 19,
    parameter int BLK_W  = 12,
    parameter int ETHR_W = 4,
    parameter int BTHR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic              err_sel,
    input  logic [ERR_W-1:0]  b1_errs,
    input  logic [ERR_W-1:0]  b2_errs,
    input  logic [FRM_W-1:0]  set_frames,
    input  logic [BLK_W-1:0]  set_blocks,
    input  logic [ETHR_W-1:0] set_err_thr,
    input  logic [BTHR_W-1:0] set_blk_thr,
    input  logic [FRM_W-1:0]  clr_frames,
    input  logic [BLK_W-1:0]  clr_blocks,
    input  logic [ETHR_W-1:0] clr_err_thr,
    input  logic [BTHR_W-1:0] clr_blk_thr,
    input  logic              force_set,
    input  logic              force_clear,
    input  logic              delta_ack,
    input  logic              irq_mask,
    output logic              sd_state,
    output logic              sd_delta,
    output logic              sd_irq
);

    sd_state_e         state;
    logic              degraded;
    logic              restart;
    logic              block_end;
    logic              block_qual;
    logic              hit;
    logic [ERR_W-1:0]  err_frame;
    logic [FRM_W-1:0]  act_frames;
    logic [BLK_W-1:0]  act_blocks;
    logic [ETHR_W-1:0] act_err_thr;
    logic [BTHR_W-1:0] act_blk_thr;

    // parameter set chosen by the current state
    always_comb begin
        degraded    = (state == SD_DEGRADED);
        err_frame   = err_sel ? b2_errs : b1_errs;
        act_frames  = degraded ? clr_frames  : set_frames;
        act_blocks  = degraded ? clr_blocks  : set_blocks;
        act_err_thr = degraded ? clr_err_thr : set_err_thr;
        act_blk_thr = degraded ? clr_blk_thr : set_blk_thr;
    end

    sdeg_block_acc #(
        .ERR_W  (ERR_W),
        .FRM_W  (FRM_W),
        .ETHR_W (ETHR_W)
    ) u_block (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .frame_valid (frame_valid),
        .degraded    (degraded),
        .err_in      (err_frame),
        .frames_cfg  (act_frames),
        .thr_cfg     (act_err_thr),
        .block_end   (block_end),
        .block_qual  (block_qual)
    );

    sdeg_interval #(
        .BLK_W  (BLK_W),
        .BTHR_W (BTHR_W)
    ) u_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .block_end  (block_end),
        .block_qual (block_qual),
        .blocks_cfg (act_blocks),
        .count_thr  (act_blk_thr),
        .hit        (hit)
    );

    sdeg_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .force_set   (force_set),
        .force_clear (force_clear),
        .delta_ack   (delta_ack),
        .irq_mask    (irq_mask),
        .state       (state),
        .restart     (restart),
        .delta       (sd_delta),
        .irq         (sd_irq)
    );

    assign sd_state = degraded;

    // R9: interrupt tracks the unmasked flag
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_irq == (sd_delta && !irq_mask)));

endmodule

// File: tb/sdeg_detector_tb_top.sv
module sdeg_detector_tb_top;

    localparam int ERR_W  = 4;
    localparam int FRM_W  = 4;
    localparam int BLK_W  = 4;
    localparam int ETHR_W = 4;
    localparam int BTHR_W = 8;

    // vector: {frame_valid, err_sel, force_set, force_clear, b1[3:0], b2[3:0], exp_state}
    localparam int NVEC = 19;
    localparam logic [12:0] VEC [NVEC] = '{
        13'b1_0_0_0_0011_0000_0,  // v0  block A frame 1
        13'b1_0_0_0_0001_0000_0,  // v1  sum 4 = thr: bad (R2)
        13'b1_0_0_0_0000_0000_0,  // v2
        13'b1_0_0_0_0000_0000_0,  // v3  good block
        13'b1_0_0_0_0000_0000_0,  // v4
        13'b1_0_0_0_0010_0000_0,  // v5  third block, interval expires (R3)
        13'b1_0_0_0_0100_0000_0,  // v6
        13'b0_0_0_0_1111_0000_0,  // v7  idle frame ignored (R11)
        13'b1_0_0_0_0000_0000_0,  // v8  bad block, count 1
        13'b1_1_0_0_0000_1001_0,  // v9  B2 selected (R6)
        13'b1_1_0_0_0000_0000_1,  // v10 second bad block: declare (R2)
        13'b1_0_0_0_0011_0000_1,  // v11 clear set: 3 not below 2 (R5)
        13'b1_0_0_0_0001_0000_1,  // v12 good, interval of 2 expires (R3)
        13'b1_0_0_0_0000_0000_1,  // v13 good
        13'b1_0_0_0_0001_0000_0,  // v14 second good: clear (R4)
        13'b1_0_0_0_1111_0000_0,  // v15
        13'b1_0_0_0_0000_0000_0,  // v16 bad block count 1
        13'b0_0_1_0_0000_0000_1,  // v17 force_set (R7)
        13'b0_0_0_1_0000_0000_0   // v18 force_clear (R7)
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_valid = 1'b0;
    logic              err_sel = 1'b0;
    logic [ERR_W-1:0]  b1_errs = '0;
    logic [ERR_W-1:0]  b2_errs = '0;
    logic [FRM_W-1:0]  set_frames = FRM_W'(2);
    logic [BLK_W-1:0]  set_blocks = BLK_W'(3);
    logic [ETHR_W-1:0] set_err_thr = ETHR_W'(4);
    logic [BTHR_W-1:0] set_blk_thr = BTHR_W'(2);
    logic [FRM_W-1:0]  clr_frames = FRM_W'(1);
    logic [BLK_W-1:0]  clr_blocks = BLK_W'(2);
    logic [ETHR_W-1:0] clr_err_thr = ETHR_W'(2);
    logic [BTHR_W-1:0] clr_blk_thr = BTHR_W'(2);
    logic              force_set = 1'b0;
    logic              force_clear = 1'b0;
    logic              delta_ack = 1'b0;
    logic              irq_mask = 1'b0;
    logic              sd_state;
    logic              sd_delta;
    logic              sd_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdeg_detector #(
        .ERR_W(ERR_W), .FRM_W(FRM_W), .BLK_W(BLK_W),
        .ETHR_W(ETHR_W), .BTHR_W(BTHR_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .err_sel(err_sel),
        .b1_errs(b1_errs), .b2_errs(b2_errs),
        .set_frames(set_frames), .set_blocks(set_blocks),
        .set_err_thr(set_err_thr), .set_blk_thr(set_blk_thr),
        .clr_frames(clr_frames), .clr_blocks(clr_blocks),
        .clr_err_thr(clr_err_thr), .clr_blk_thr(clr_blk_thr),
        .force_set(force_set), .force_clear(force_clear),
        .delta_ack(delta_ack), .irq_mask(irq_mask),
        .sd_state(sd_state), .sd_delta(sd_delta), .sd_irq(sd_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge: drive, then wait for the next falling edge
    task automatic step(input bit fv, input bit sel, input logic [3:0] e1,
                        input logic [3:0] e2, input bit fs, input bit fc, input bit ack);
        frame_valid = fv;
        err_sel     = sel;
        b1_errs     = e1;
        b2_errs     = e2;
        force_set   = fs;
        force_clear = fc;
        delta_ack   = ack;
        @(negedge clk);
        frame_valid = 1'b0;
        force_set   = 1'b0;
        force_clear = 1'b0;
        delta_ack   = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(sd_state == 1'b0, "R1 state", sd_state, 0);
        check(sd_delta == 1'b0, "R1 delta", sd_delta, 0);
        check(sd_irq   == 1'b0, "R1 irq", sd_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            step(v[12], v[11], v[8:5], v[4:1], v[10], v[9], 1'b0);
            check(sd_state == v[0], $sformatf("R2/R3/R4/R5/R6/R7/R11 vector %0d state", i),
                  sd_state, v[0]);
        end

        // R8 R9: sticky flag after changes, mask gating
        check(sd_delta == 1'b1, "R8 delta after changes", sd_delta, 1);
        check(sd_irq == 1'b1, "R9 irq unmasked", sd_irq, 1);
        irq_mask = 1'b1;
        #1;
        check(sd_irq == 1'b0, "R9 irq masked", sd_irq, 0);
        irq_mask = 1'b0;
        step(1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1);
        check(sd_delta == 1'b0, "R8 ack clears delta", sd_delta, 0);
        check(sd_irq == 1'b0, "R9 irq follows ack", sd_irq, 0);

        // R7: both forces together from clear stay clear, no change flag
        step(1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0);
        check(sd_state == 1'b0, "R7 both forces give clear", sd_state, 0);
        check(sd_delta == 1'b0, "R8 no change no delta", sd_delta, 0);

        // R10: force_clear in clear state still restarts the interval
        step(1'b1, 1'b0, 4'd4, 4'd0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 4'd4, 4'd0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        check(sd_state == 1'b0, "R10 restart discards earlier bad block", sd_state, 0);
        step(1'b1, 1'b0, 4'd4, 4'd0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        check(sd_state == 1'b1, "R2 declare after two bad blocks", sd_state, 1);

        // R8: change in the acknowledge cycle keeps the flag
        step(1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b1);
        check(sd_state == 1'b0, "R7 force_clear", sd_state, 0);
        check(sd_delta == 1'b1, "R8 change wins over ack", sd_delta, 1);

        // R12: zero frames per block acts as one
        set_frames  = '0;
        set_err_thr = ETHR_W'(1);
        set_blk_thr = BTHR_W'(1);
        step(1'b1, 1'b0, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0);
        check(sd_state == 1'b1, "R12 zero frames treated as one", sd_state, 1);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule